// File: doc/BRIEF.md
# PLL Digital Lock Detector

This block turns the per-comparison result of a phase-frequency detector into a lock indication that is stable against single noisy comparisons. A strobe marks each reference comparison, and a flag with it reports whether the phase error for that comparison stayed within one reference period. While the loop is unlocked, the block waits for an unbroken run of good comparisons before it reports lock. While locked, it waits for an unbroken run of bad comparisons before it reports loss of lock. The run needed to gain lock is longer than the run needed to lose it, and a select input picks a short or a long pair of run lengths.

A bypass mode sends the detector's raw comparison signal straight to the lock output. A mute output tells the local-oscillator path to stay quiet while the counted indication says the loop is unlocked. A restart strobe, pulsed on every frequency change, puts the detector back into the unlocked state with an empty run.

Top module: `lockdet_top`

## Requirements
- R1: After reset, and one cycle after any restart strobe, the counted state is unlocked (lock_o low with bypass_i = 0) and the run count is zero.
- R2: With run_sel_i = 0 and the state unlocked, the state becomes locked on the 15th consecutive valid comparison with small_err_i = 1. lock_o rises in the cycle after the clock edge that sampled that comparison.
- R3: With run_sel_i = 0 and the state locked, the state becomes unlocked on the 3rd consecutive valid comparison with small_err_i = 0.
- R4: With run_sel_i = 1, the run lengths are 31 good comparisons to lock and 7 bad comparisons to unlock.
- R5: A valid comparison that does not extend the current run (bad while unlocked, good while locked) resets the run count to zero and leaves the state unchanged.
- R6: Cycles with cmp_valid_i = 0 change neither the state nor the run count, whatever small_err_i is.
- R7: With bypass_i = 1, lock_o equals raw_pd_i in the same cycle. Counting continues underneath, and lock_o shows the counted state again once bypass_i returns to 0.
- R8: mute_o is 1 exactly when mute_en_i = 1, bypass_i = 0 and the counted state is unlocked. Otherwise it is 0.
- R9: A restart strobe wins over a comparison sampled in the same cycle.
- R10: run_sel_i is applied at each comparison: the run reached so far is compared with the length that the current selection gives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid_i | input | 1 | One-cycle strobe, one per reference comparison |
| small_err_i | input | 1 | 1 when the phase error of this comparison is within one reference period |
| raw_pd_i | input | 1 | Raw phase-detector comparison signal for bypass mode |
| bypass_i | input | 1 | 1 selects the raw signal on lock_o |
| run_sel_i | input | 1 | 0: runs of 15/3, 1: runs of 31/7 |
| mute_en_i | input | 1 | Allows mute_o while unlocked |
| restart_i | input | 1 | Frequency-change strobe: forces the unlocked state with an empty run |
| lock_o | output | 1 | Lock indication |
| mute_o | output | 1 | Mute request to the LO path |

## Verification
The run count is internal, so a wrong count shows at the ports only when a lock or unlock decision comes one or more comparisons early or late. The bench therefore drives runs that stop one comparison short of each threshold and then complete it. A broken run or an unwanted reset of the count shows up as a missing transition, no sooner than the full run length later (up to 31 comparisons). A wrong state register shows at lock_o and mute_o in the next cycle, and the reference model compares both outputs on every clock.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_HELD = 1'b1
  } lock_state_e;

  // Run length that ends the present state.
  function automatic int unsigned run_target(input logic held, input logic long_sel,
                                             input int unsigned acq_short,
                                             input int unsigned acq_long,
                                             input int unsigned rel_short,
                                             input int unsigned rel_long);
    if (held) return long_sel ? rel_long : rel_short;
    return long_sel ? acq_long : acq_short;
  endfunction

  // A comparison extends the run when it argues for leaving the present state.
  function automatic logic extends_run(input logic held, input logic small_err);
    return held ? ~small_err : small_err;
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/lockdet_qualify.sv
module lockdet_qualify
  import lockdet_pkg::*;
#(
  parameter int unsigned ACQ_SHORT = 15,
  parameter int unsigned ACQ_LONG  = 31,
  parameter int unsigned REL_SHORT = 3,
  parameter int unsigned REL_LONG  = 7,
  parameter int unsigned CNT_W     = 6
) (
  input  logic             held_i,
  input  logic             cmp_valid_i,
  input  logic             small_err_i,
  input  logic             run_sel_i,
  output logic             step_o,
  output logic             brk_o,
  output logic [CNT_W-1:0] target_o
);

  logic ext;

  always_comb begin
    ext      = extends_run(held_i, small_err_i);
    step_o   = cmp_valid_i & ext;
    brk_o    = cmp_valid_i & ~ext;
    target_o = CNT_W'(run_target(held_i, run_sel_i, ACQ_SHORT, ACQ_LONG,
                                 REL_SHORT, REL_LONG));
  end

endmodule

// File: rtl/lockdet_run_ctr.sv
module lockdet_run_ctr #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic             brk_i,
  input  logic [CNT_W-1:0] target_i,
  output logic [CNT_W-1:0] run_o,
  output logic             done_o
);

  logic [CNT_W-1:0] run_q;
  logic [CNT_W:0]   run_inc;

  assign run_inc = {1'b0, run_q} + 1'b1;
  assign done_o  = step_i & (run_inc >= {1'b0, target_i});
  assign run_o   = run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          run_q <= '0;
    else if (clear_i || brk_i || done_o) run_q <= '0;
    else if (step_i)                     run_q <= run_inc[CNT_W-1:0];
  end

  // R6
  idle_holds_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !step_i && !brk_i) |=> $stable(run_q));

  // R5
  break_empties_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_i |=> (run_q == '0));

  // R2
  step_advances_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !done_o && !clear_i) |=> (run_q == $past(run_q) + 1'b1));

endmodule

// File: rtl/lockdet_state.sv
module lockdet_state
  import lockdet_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic done_i,
  output logic held_o
);

  lock_state_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= ST_HUNT;
    else if (clear_i) state_q <= ST_HUNT;
    else if (done_i)  state_q <= (state_q == ST_HELD) ? ST_HUNT : ST_HELD;
  end

  assign held_o = (state_q == ST_HELD);

  // R1
  restart_unlocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !held_o);

  // R6
  state_only_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !done_i) |=> $stable(held_o));

endmodule

// File: rtl/lockdet_top.sv
module lockdet_top
  import lockdet_pkg::*;
#(
  parameter int unsigned ACQ_SHORT = 15,
  parameter int unsigned ACQ_LONG  = 31,
  parameter int unsigned REL_SHORT = 3,
  parameter int unsigned REL_LONG  = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_valid_i,
  input  logic small_err_i,
  input  logic raw_pd_i,
  input  logic bypass_i,
  input  logic run_sel_i,
  input  logic mute_en_i,
  input  logic restart_i,
  output logic lock_o,
  output logic mute_o
);

  localparam int unsigned RUN_MAX = max4(ACQ_SHORT, ACQ_LONG, REL_SHORT, REL_LONG);
  localparam int unsigned CNT_W   = $clog2(RUN_MAX + 2);

  logic             held;
  logic             step;
  logic             brk;
  logic             done;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] run;

  lockdet_qualify #(
    .ACQ_SHORT(ACQ_SHORT), .ACQ_LONG(ACQ_LONG),
    .REL_SHORT(REL_SHORT), .REL_LONG(REL_LONG), .CNT_W(CNT_W)
  ) i_qualify (
    .held_i(held), .cmp_valid_i(cmp_valid_i), .small_err_i(small_err_i),
    .run_sel_i(run_sel_i), .step_o(step), .brk_o(brk), .target_o(target)
  );

  lockdet_run_ctr #(.CNT_W(CNT_W)) i_run_ctr (
    .clk(clk), .rst_n(rst_n), .clear_i(restart_i), .step_i(step), .brk_i(brk),
    .target_i(target), .run_o(run), .done_o(done)
  );

  lockdet_state i_state (
    .clk(clk), .rst_n(rst_n), .clear_i(restart_i), .done_i(done), .held_o(held)
  );

  assign lock_o = bypass_i ? raw_pd_i : held;
  assign mute_o = mute_en_i & ~bypass_i & ~held;

  // R2
  lock_needs_full_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held) |-> ($past(cmp_valid_i) && $past(small_err_i) &&
                     ({1'b0, $past(run)} + 1'b1 >= {1'b0, $past(target)})));

  // R3
  unlock_needs_bad_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(held) && !$past(restart_i)) |-> ($past(cmp_valid_i) && !$past(small_err_i)));

  // R8
  mute_only_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mute_o |-> (!lock_o && !bypass_i));

  // R9
  restart_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (run == '0));

endmodule

// File: tb/test_lockdet_top.sv
module test_lockdet_top;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_valid_i = 1'b0, small_err_i = 1'b0, raw_pd_i = 1'b0;
  logic bypass_i = 1'b0, run_sel_i = 1'b0, mute_en_i = 1'b0, restart_i = 1'b0;
  logic lock_o, mute_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  string phase_req = "R1";

  int m_held = 0;
  int m_run  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lockdet_top i_lockdet_top (
    .clk(clk), .rst_n(rst_n), .cmp_valid_i(cmp_valid_i), .small_err_i(small_err_i),
    .raw_pd_i(raw_pd_i), .bypass_i(bypass_i), .run_sel_i(run_sel_i),
    .mute_en_i(mute_en_i), .restart_i(restart_i), .lock_o(lock_o), .mute_o(mute_o)
  );

  // Behavioural reference model
  always @(posedge clk) begin
    int need;
    bit good;
    if (!rst_n || restart_i) begin
      m_held = 0; m_run = 0;
    end else if (cmp_valid_i) begin
      good = m_held ? !small_err_i : small_err_i;
      if (m_held) need = run_sel_i ? 7 : 3;
      else        need = run_sel_i ? 31 : 15;
      if (good) begin
        m_run++;
        if (m_run >= need) begin m_held = 1 - m_held; m_run = 0; end
      end else m_run = 0;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check({phase_req, " lock_o"}, lock_o, bypass_i ? raw_pd_i : logic'(m_held != 0));
      check({phase_req, " mute_o"}, mute_o, mute_en_i & ~bypass_i & ~logic'(m_held != 0));
    end
  end

  task automatic drive(input logic v, input logic s);
    @(posedge clk); #2;
    cmp_valid_i = v; small_err_i = s; restart_i = 1'b0;
  endtask

  task automatic run_n(input int n, input logic s);
    for (int k = 0; k < n; k++) drive(1'b1, s);
  endtask

  task automatic settle();
    @(posedge clk); #2;
    cmp_valid_i = 1'b0; restart_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic restart_pulse();
    @(posedge clk); #2;
    restart_i = 1'b1; cmp_valid_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    mute_en_i = 1'b1;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset lock", lock_o, 1'b0);
    check("R8 reset mute", mute_o, 1'b1);

    // R2: 14 good stays unlocked, 15th locks
    phase_req = "R2";
    run_n(14, 1'b1); settle();
    check("R2 14 good", lock_o, 1'b0);
    run_n(1, 1'b1); settle();
    check("R2 15th good", lock_o, 1'b1);
    check("R8 locked mute", mute_o, 1'b0);

    // R3: 2 bad, then a good breaks, then 3 bad drops
    phase_req = "R5";
    run_n(2, 1'b0); drive(1'b1, 1'b1); settle();
    check("R5 break keeps lock", lock_o, 1'b1);
    phase_req = "R3";
    run_n(2, 1'b0); settle();
    check("R3 2 bad", lock_o, 1'b1);
    run_n(1, 1'b0); settle();
    check("R3 3rd bad", lock_o, 1'b0);

    // R5 while unlocked: 10 good, 1 bad, 14 good -> still unlocked
    phase_req = "R5";
    run_n(10, 1'b1); drive(1'b1, 1'b0); run_n(14, 1'b1); settle();
    check("R5 run restarted", lock_o, 1'b0);
    // R6: gaps with small_err toggling do nothing
    phase_req = "R6";
    for (int k = 0; k < 6; k++) drive(1'b0, logic'(k % 2));
    settle();
    check("R6 no valid", lock_o, 1'b0);
    run_n(1, 1'b1); settle();
    check("R6 run kept across gap", lock_o, 1'b1);

    // R9: restart with a valid comparison in the same cycle
    phase_req = "R9";
    @(posedge clk); #2; restart_i = 1'b1; cmp_valid_i = 1'b1; small_err_i = 1'b0;
    settle();
    check("R9 restart wins", lock_o, 1'b0);

    // R4: long runs
    phase_req = "R4";
    run_sel_i = 1'b1;
    run_n(30, 1'b1); settle();
    check("R4 30 good", lock_o, 1'b0);
    run_n(1, 1'b1); settle();
    check("R4 31st good", lock_o, 1'b1);
    run_n(6, 1'b0); settle();
    check("R4 6 bad", lock_o, 1'b1);
    run_n(1, 1'b0); settle();
    check("R4 7th bad", lock_o, 1'b0);

    // R10: run of 20 under long select, switch to short -> next good locks
    phase_req = "R10";
    run_n(20, 1'b1); settle();
    check("R10 20 good long", lock_o, 1'b0);
    run_sel_i = 1'b0;
    run_n(1, 1'b1); settle();
    check("R10 switch to short", lock_o, 1'b1);

    // R1: restart while locked
    phase_req = "R1";
    restart_pulse(); settle();
    check("R1 restart clears lock", lock_o, 1'b0);

    // R7: bypass follows raw, counting continues
    phase_req = "R7";
    bypass_i = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); #2; raw_pd_i = logic'((k * 3) % 2); cmp_valid_i = 1'b1; small_err_i = 1'b1;
      #1; check("R7 raw follow", lock_o, raw_pd_i);
    end
    run_n(7, 1'b1); settle();
    check("R8 bypass mute off", mute_o, 1'b0);
    bypass_i = 1'b0; raw_pd_i = 1'b0;
    #1; check("R7 counted after bypass", lock_o, 1'b1);

    // R8: mute disabled while unlocked
    phase_req = "R8";
    restart_pulse(); settle();
    mute_en_i = 1'b0; #1;
    check("R8 mute disabled", mute_o, 1'b0);
    mute_en_i = 1'b1; #1;
    check("R8 mute enabled unlocked", mute_o, 1'b1);

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule